// File: doc/BRIEF.md
# Configurable PLA Function Block

This block is a programmable AND-OR array. A bank of 36 input signals is presented to the AND plane in both polarities. Each of 48 product terms ANDs any chosen subset of those 72 literals. A fully programmable OR plane then lets each of 16 sum outputs collect any subset of the product terms. The sum outputs feed 16 downstream logic cells.

Two groups of terms have extra roles. Terms 0 to 7 may be claimed as control terms. A claimed term is driven out on its own control output and is withheld from the OR plane. Terms 8 to 15 may be switched into foldback mode. A foldback term is withheld from the OR plane, and its inverted value (a NAND of its literals) returns to the AND plane as one of 8 extra literals. All other terms may use these extra literals, which builds wider functions in one pass. There is only one level of feedback: a foldback term never uses feedback literals itself.

The configuration is one long chain. It is shifted in serially, one bit per clock while `cfg_shift` is high. A pulse on `cfg_load` then arms the array. All outputs stay 0 until the array is armed, and they go back to 0 as soon as the chain is shifted again.

Top module: `pla_fblock`

## Requirements
- R1: After reset, and at any time the array is not armed, `sum_out` and `ctrl_out` are all 0 whatever `in_bus` holds.
- R2: Each clock with `cfg_shift` high shifts `cfg_din` into chain bit 0 and moves every bit up by one. The first bit shifted in therefore ends at the top position, bit 4623. The same clock disarms the array. A clock with `cfg_load` high and `cfg_shift` low arms it. The chain layout, from bit 0 upward, is as follows. First come the 48 AND masks of 80 bits each, with term k at bits k*80 to k*80+79. Next come the 16 OR masks of 48 bits each, starting at 3840, with output j at 3840+j*48 and bit k of each mask selecting term k. Next are the 8 control-claim bits at 4608 to 4615. Last are the 8 foldback-enable bits at 4616 to 4623.
- R3: When armed, a product term is 1 exactly when every literal selected in its mask is 1. In an AND mask, bit i (0 to 35) selects `in_bus[i]`, bit 36+i selects its complement, and bit 72+f selects feedback literal f.
- R4: A product term with no literal selected is 0, so it never drives a sum high.
- R5: When armed, `sum_out[j]` is the OR of every eligible product term selected by OR mask j.
- R6: When claim bit i is set, `ctrl_out[i]` equals term i and term i is left out of every sum. When claim bit i is clear, `ctrl_out[i]` is 0 and term i acts as an ordinary term in the OR plane.
- R7: When foldback bit f is set, term 8+f is left out of every sum and feedback literal f equals the inverse of term 8+f. The feedback bits (72 to 79) in the mask of any term 8 to 15 have no effect.
- R8: When foldback bit f is clear, term 8+f is an ordinary OR-plane term and feedback literal f reads as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_shift | input | 1 | Shift one configuration bit into the chain this clock |
| cfg_din | input | 1 | Serial configuration data, first bit lands at the top of the chain |
| cfg_load | input | 1 | Arm the array with the chain contents |
| in_bus | input | 36 | Array input signals |
| sum_out | output | 16 | Sum outputs of the OR plane |
| ctrl_out | output | 8 | Control-term outputs |

## Verification
A single misplaced or stuck chain bit appears at the ports only when a pattern excites the term or sum it controls. The bench therefore compares every output against an independent model on every clock, over both hand-built and randomly built configurations. The array is combinational after arming, so a wrong mask, claim or foldback bit shows in the same cycle the exciting input is applied. A wrong arm flag shows on the clock after the shift or load edge.

// File: rtl/pla_pkg.sv
package pla_pkg;
  parameter int PLA_N_IN    = 36;
  parameter int PLA_N_PT    = 48;
  parameter int PLA_N_OUT   = 16;
  parameter int PLA_N_CT    = 8;
  parameter int PLA_N_FB    = 8;
  parameter int PLA_FB_BASE = 8;
endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int TOTAL = 4624
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_shift,
  input  logic             cfg_din,
  input  logic             cfg_load,
  output logic             rst_sn,
  output logic [TOTAL-1:0] image,
  output logic             armed
);
  logic [1:0]       sync_q;
  logic [TOTAL-1:0] chain_q, chain_d;
  logic             done_q, done_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sn = sync_q[1];

  always_comb begin
    chain_d = {chain_q[TOTAL-2:0], cfg_din};
    if (cfg_shift)     done_d = 1'b0;
    else if (cfg_load) done_d = 1'b1;
    else               done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      chain_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (cfg_shift) chain_q <= chain_d;
      done_q <= done_d;
    end
  end

  assign image = chain_q;
  assign armed = done_q;

  AST_SHIFT_DISARMS: assert property (@(posedge clk) disable iff (!rst_sn)
    cfg_shift |=> !armed) else $error("shift left array armed"); // R2
  AST_LOAD_ARMS: assert property (@(posedge clk) disable iff (!rst_sn)
    (cfg_load && !cfg_shift) |=> armed) else $error("load did not arm"); // R2
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN    = pla_pkg::PLA_N_IN,
  parameter int N_PT    = pla_pkg::PLA_N_PT,
  parameter int N_FB    = pla_pkg::PLA_N_FB,
  parameter int FB_BASE = pla_pkg::PLA_FB_BASE,
  localparam int NB     = 2 * N_IN,
  localparam int LW     = NB + N_FB
) (
  input  logic               clk,
  input  logic               rst_sn,
  input  logic [N_IN-1:0]    in_bus,
  input  logic [N_PT*LW-1:0] and_cfg,
  input  logic [N_FB-1:0]    fb_en,
  output logic [N_PT-1:0]    pterm
);
  logic [NB-1:0]   lit_base;
  logic [N_FB-1:0] fb_lit;
  logic [LW-1:0]   lit_full;
  logic [LW-1:0]   lit_fbterm;

  assign lit_base   = {~in_bus, in_bus};
  assign lit_full   = {fb_lit, lit_base};
  assign lit_fbterm = {{N_FB{1'b1}}, lit_base};

  for (genvar k = 0; k < N_PT; k++) begin : g_term
    logic [LW-1:0] mask;
    assign mask = and_cfg[k*LW +: LW];

    if (k >= FB_BASE && k < FB_BASE + N_FB) begin : g_fold
      assign pterm[k] = (|mask[NB-1:0]) & (&(lit_fbterm | ~mask));
      assign fb_lit[k-FB_BASE] = fb_en[k-FB_BASE] ? ~pterm[k] : 1'b1;
    end else begin : g_plain
      assign pterm[k] = (|mask) & (&(lit_full | ~mask));
      AST_FB_BLOCKS_TERM: assert property (@(posedge clk) disable iff (!rst_sn)
        ((mask[LW-1:NB] & ~fb_lit) != '0) |-> !pterm[k])
        else $error("low feedback literal failed to block term"); // R7
    end

    AST_EMPTY_TERM_ZERO: assert property (@(posedge clk) disable iff (!rst_sn)
      (mask == '0) |-> !pterm[k]) else $error("empty term high"); // R4
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_PT    = pla_pkg::PLA_N_PT,
  parameter int N_OUT   = pla_pkg::PLA_N_OUT,
  parameter int N_CT    = pla_pkg::PLA_N_CT,
  parameter int N_FB    = pla_pkg::PLA_N_FB,
  parameter int FB_BASE = pla_pkg::PLA_FB_BASE
) (
  input  logic [N_PT-1:0]       pterm,
  input  logic [N_OUT*N_PT-1:0] or_cfg,
  input  logic [N_CT-1:0]       ct_en,
  input  logic [N_FB-1:0]       fb_en,
  input  logic                  armed,
  output logic [N_OUT-1:0]      sum_out,
  output logic [N_CT-1:0]       ctrl_out
);
  logic [N_PT-1:0] eligible;
  logic [N_PT-1:0] live;

  for (genvar k = 0; k < N_PT; k++) begin : g_elig
    if (k < N_CT) begin : g_ct
      assign eligible[k] = ~ct_en[k];
    end else if (k >= FB_BASE && k < FB_BASE + N_FB) begin : g_fb
      assign eligible[k] = ~fb_en[k-FB_BASE];
    end else begin : g_any
      assign eligible[k] = 1'b1;
    end
  end

  assign live = pterm & eligible;

  for (genvar j = 0; j < N_OUT; j++) begin : g_sum
    assign sum_out[j] = armed & (|(live & or_cfg[j*N_PT +: N_PT]));
  end

  assign ctrl_out = {N_CT{armed}} & ct_en & pterm[N_CT-1:0];
endmodule

// File: rtl/pla_fblock.sv
module pla_fblock #(
  parameter int N_IN    = pla_pkg::PLA_N_IN,
  parameter int N_PT    = pla_pkg::PLA_N_PT,
  parameter int N_OUT   = pla_pkg::PLA_N_OUT,
  parameter int N_CT    = pla_pkg::PLA_N_CT,
  parameter int N_FB    = pla_pkg::PLA_N_FB,
  parameter int FB_BASE = pla_pkg::PLA_FB_BASE,
  localparam int LW     = 2 * N_IN + N_FB,
  localparam int OR_B   = N_PT * LW,
  localparam int CT_B   = OR_B + N_OUT * N_PT,
  localparam int FB_B   = CT_B + N_CT,
  localparam int TOTAL  = FB_B + N_FB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_shift,
  input  logic             cfg_din,
  input  logic             cfg_load,
  input  logic [N_IN-1:0]  in_bus,
  output logic [N_OUT-1:0] sum_out,
  output logic [N_CT-1:0]  ctrl_out
);
  logic             rst_sn;
  logic [TOTAL-1:0] image;
  logic             armed;
  logic [N_PT-1:0]  pterm;

  pla_cfg_chain #(.TOTAL(TOTAL)) u_chain (
    .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_din(cfg_din),
    .cfg_load(cfg_load), .rst_sn(rst_sn), .image(image), .armed(armed)
  );

  pla_and_plane #(.N_IN(N_IN), .N_PT(N_PT), .N_FB(N_FB), .FB_BASE(FB_BASE)) u_and (
    .clk(clk), .rst_sn(rst_sn), .in_bus(in_bus),
    .and_cfg(image[OR_B-1:0]), .fb_en(image[FB_B +: N_FB]), .pterm(pterm)
  );

  pla_or_plane #(.N_PT(N_PT), .N_OUT(N_OUT), .N_CT(N_CT), .N_FB(N_FB),
                 .FB_BASE(FB_BASE)) u_or (
    .pterm(pterm), .or_cfg(image[CT_B-1:OR_B]), .ct_en(image[CT_B +: N_CT]),
    .fb_en(image[FB_B +: N_FB]), .armed(armed),
    .sum_out(sum_out), .ctrl_out(ctrl_out)
  );

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    !armed |-> (sum_out == '0 && ctrl_out == '0))
    else $error("outputs active while unarmed"); // R1
endmodule

// File: tb/sim_pla_fblock.sv
module sim_pla_fblock;
  localparam int NI = 36, NP = 48, NO = 16, NC = 8, NF = 8, LWB = 80;
  localparam int OB = NP * LWB, CB = OB + NO * NP, FBB = CB + NC, TOT = FBB + NF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_shift = 1'b0, cfg_din = 1'b0, cfg_load = 1'b0;
  logic [NI-1:0] in_bus = '0;
  logic [NO-1:0] sum_out;
  logic [NC-1:0] ctrl_out;

  int checks = 0, errors = 0;
  bit finished = 0;
  string cur_tag = "R1";

  logic [TOT-1:0] img;
  logic [TOT-1:0] m_chain;
  bit m_armed;

  pla_fblock u0 (.clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_din(cfg_din),
                 .cfg_load(cfg_load), .in_bus(in_bus), .sum_out(sum_out), .ctrl_out(ctrl_out));

  always #2 clk = ~clk;

  function automatic void calc(input logic [TOT-1:0] c, input logic [NI-1:0] x,
                               output logic [NO-1:0] s, output logic [NC-1:0] ct);
    bit lit[LWB];
    bit p[NP];
    for (int i = 0; i < NI; i++) begin lit[i] = x[i]; lit[NI+i] = !x[i]; end
    for (int f = 0; f < NF; f++) begin
      int k = 8 + f; bit any = 0; bit all = 1;
      for (int l = 0; l < 2*NI; l++) if (c[k*LWB+l]) begin any = 1; if (!lit[l]) all = 0; end
      p[k] = any && all;
      lit[2*NI+f] = c[FBB+f] ? !p[k] : 1'b1;
    end
    for (int k = 0; k < NP; k++) begin
      if (k < 8 || k >= 16) begin
        bit any = 0; bit all = 1;
        for (int l = 0; l < LWB; l++) if (c[k*LWB+l]) begin any = 1; if (!lit[l]) all = 0; end
        p[k] = any && all;
      end
    end
    s = '0; ct = '0;
    for (int i = 0; i < NC; i++) ct[i] = c[CB+i] && p[i];
    for (int o = 0; o < NO; o++)
      for (int k = 0; k < NP; k++) begin
        bit use_k = !(k < 8 && c[CB+k]) && !(k >= 8 && k < 16 && c[FBB+k-8]);
        if (use_k && c[OB+o*NP+k] && p[k]) s[o] = 1'b1;
      end
  endfunction

  // behavioural model of chain and arm flag
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_chain = '0; m_armed = 0; end
    else begin
      if (cfg_shift) begin m_chain = m_chain << 1; m_chain[0] = cfg_din; m_armed = 0; end
      else if (cfg_load) m_armed = 1;
    end
  end

  task automatic report(string tag, logic [NO-1:0] s, logic [NC-1:0] ct,
                        logic [NO-1:0] es, logic [NC-1:0] ec);
    checks++;
    if (s !== es || ct !== ec) begin
      errors++;
      $display("FAIL %s sum=%h ctrl=%h expected sum=%h ctrl=%h", tag, s, ct, es, ec);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      logic [NO-1:0] es; logic [NC-1:0] ec;
      if (m_armed) calc(m_chain, in_bus, es, ec);
      else begin es = '0; ec = '0; end
      report(cur_tag, sum_out, ctrl_out, es, ec);
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic apply(logic [NI-1:0] v);
    @(negedge clk); in_bus = v;
  endtask

  task automatic hand(string tag, logic [NI-1:0] v, logic [NO-1:0] es, logic [NC-1:0] ec);
    apply(v);
    @(posedge clk); #1;
    report(tag, sum_out, ctrl_out, es, ec);
  endtask

  task automatic shift_all();
    for (int p = TOT - 1; p >= 0; p--) begin
      @(negedge clk); cfg_shift = 1'b1; cfg_din = img[p];
    end
    @(negedge clk); cfg_shift = 1'b0; cfg_din = 1'b0;
  endtask

  task automatic pulse_load();
    @(negedge clk); cfg_load = 1'b1;
    @(negedge clk); cfg_load = 1'b0;
  endtask

  task automatic lit_on(int t, int l);  img[t*LWB+l] = 1'b1; endtask
  task automatic or_on(int o, int t);   img[OB+o*NP+t] = 1'b1; endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cur_tag = "R1";
    hand("R1 reset state", 36'h0, '0, '0);
    hand("R1 unarmed ignores inputs", 36'hF_FFFF_FFFF, '0, '0);

    // hand-built configuration
    img = '0;
    lit_on(0, 0);  img[CB+0] = 1'b1; or_on(0, 0);        // claimed control term
    lit_on(1, 3);  or_on(7, 1);                          // unclaimed control term
    lit_on(20, 0); lit_on(20, 37); lit_on(21, 5);
    or_on(3, 20); or_on(3, 21);
    or_on(4, 22);                                        // empty term
    lit_on(8, 0); lit_on(8, 1); lit_on(8, 73); img[FBB+0] = 1'b1;
    or_on(9, 8); lit_on(30, 72); lit_on(30, 4); or_on(9, 30);
    lit_on(9, 6); or_on(10, 9);                          // foldback disabled
    lit_on(31, 73); lit_on(31, 7); or_on(11, 31);

    cur_tag = "R2";
    shift_all();
    hand("R1 shifted but not armed", 36'h1, '0, '0);
    pulse_load();
    cur_tag = "R5";
    hand("R2 msb-first placement", 36'h1, 16'h0008, 8'h01);
    hand("R3 true and complement", 36'h3, 16'h0000, 8'h01);
    hand("R5 second term of sum", 36'h20, 16'h0008, 8'h00);
    hand("R6 unclaimed term in OR plane", 36'h8, 16'h0080, 8'h00);
    hand("R7 foldback high lets term", 36'h10, 16'h0200, 8'h00);
    hand("R7 foldback low blocks term", 36'h13, 16'h0000, 8'h01);
    hand("R7 foldback mixed", 36'h11, 16'h0208, 8'h01);
    hand("R8 disabled foldback ordinary", 36'h40, 16'h0400, 8'h00);
    hand("R8 disabled feedback reads 1", 36'h80, 16'h0800, 8'h00);
    hand("R4 empty term all ones", 36'hF_FFFF_FFFF, 16'h0C88, 8'h01);

    cur_tag = "R2";
    @(negedge clk); cfg_shift = 1'b1; cfg_din = 1'b0;
    @(negedge clk); cfg_shift = 1'b0;
    hand("R2 shift disarms", 36'h1, '0, '0);
    pulse_load();
    for (int i = 0; i < 20; i++) apply({$urandom, $urandom} & 36'hF_FFFF_FFFF);

    // random sparse configuration, model comparison every clock
    img = '0;
    for (int t = 0; t < NP; t++) begin
      lit_on(t, $urandom_range(0, LWB-1));
      if ($urandom_range(0, 1) == 1) lit_on(t, $urandom_range(0, LWB-1));
    end
    for (int o = 0; o < NO; o++)
      for (int r = 0; r < 4; r++) or_on(o, $urandom_range(0, NP-1));
    img[CB +: NC] = 8'($urandom);
    img[FBB +: NF] = 8'($urandom);
    cur_tag = "R2";
    shift_all();
    pulse_load();
    cur_tag = "R5";
    for (int i = 0; i < 200; i++) apply({$urandom, $urandom} & 36'hF_FFFF_FFFF);
    cur_tag = "R3";
    for (int i = 0; i < 36; i++) apply(36'h1 << i);
    for (int i = 0; i < 36; i++) apply(~(36'h1 << i));
    @(negedge clk);
    finish_run();
  end
endmodule